// File: doc/BRIEF.md
# Integer Operate Unit with Scaled Add

This block is the integer execution slice of a 64-bit processor datapath. Each accepted operation takes operand A from a register and operand B from either a register or an 8-bit immediate. It performs one of eight operations: add, subtract, AND, OR, XOR, shift left logical, shift right logical or shift right arithmetic.

Three modifier controls refine the chosen operation. A scale field multiplies operand A by 4 or 8 before an add or subtract. A longword flag narrows an add or subtract to a signed 32-bit result. A complement flag inverts operand B for the three logic operations, which gives bit-clear, or-not and equivalence.

The result is registered. A valid strobe accompanies it one clock after the operation is presented. Overflow traps, multiplication and instruction decoding belong to neighbouring blocks.

Top module: `int_op_unit`

## Requirements
- R1: While and after synchronous reset, with no operation presented, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` equals the previous cycle's `in_valid`. `result` changes only in the cycle after `in_valid` was 1 and otherwise holds its value.
- R3: Add (`op`=0) and subtract (`op`=1) produce the 64-bit two's-complement sum or difference of scaled A and B. Carries and borrows out of bit 63 are discarded.
- R4: `scale` = 1 multiplies A by 4 and `scale` = 2 multiplies A by 8 before the add or subtract. `scale` = 0 and `scale` = 3 leave A unchanged.
- R5: With `long_mode` = 1, an add or subtract result keeps its low 32 bits, and bits 63:32 are copies of bit 31.
- R6: AND (`op`=2), OR (`op`=3) and XOR (`op`=4) combine A with B, or with the bitwise complement of B when `inv_b` = 1.
- R7: Shift left logical (`op`=5), shift right logical (`op`=6) and shift right arithmetic (`op`=7) shift A by B[5:0]. Higher bits of B are ignored, and logical shifts fill with zeros.
- R8: The arithmetic right shift fills the vacated upper bits with A[63].
- R9: With `use_imm` = 1, B is `imm` zero-extended to 64 bits, and any complement is applied after the extension. `b_reg` is then ignored.
- R10: `scale` and `long_mode` have no effect on logic or shift operations. `inv_b` has no effect on add, subtract or shift operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 3 | Operation select (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 sll, 6 srl, 7 sra) |
| scale | input | 2 | Operand A scale for add/sub (1: x4, 2: x8, else x1) |
| long_mode | input | 1 | 32-bit signed result for add/sub |
| inv_b | input | 1 | Complement operand B for logic operations |
| use_imm | input | 1 | Take operand B from the immediate |
| a | input | 64 | Operand A |
| b_reg | input | 64 | Register form of operand B |
| imm | input | 8 | Immediate form of operand B |
| out_valid | output | 1 | Result valid strobe |
| result | output | 64 | Registered result |

## Verification
The assertions assume that the control inputs are known whenever `in_valid` is high. They also assume that `op` takes only the eight defined codes, so every checked property has a defined operation behind it. The stimulus sets every control and operand at a falling edge before raising `in_valid`, and it lowers `in_valid` between operations, so the hold property is tested on idle cycles. The sweep covers every combination of operation, scale, longword, complement and immediate selection over operand patterns. These patterns include the sign bit, all-ones values and shift counts with high bits of B set.

// File: rtl/iou_pkg.sv
package iou_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SLL = 3'd5,
        OP_SRL = 3'd6,
        OP_SRA = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SC_X1  = 2'd0,
        SC_X4  = 2'd1,
        SC_X8  = 2'd2,
        SC_RSV = 2'd3
    } scale_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shdir_e;

    function automatic logic is_arith(input op_e o);
        return (o == OP_ADD) || (o == OP_SUB);
    endfunction

    function automatic logic is_logic(input op_e o);
        return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
    endfunction

    function automatic shdir_e shift_dir(input op_e o);
        case (o)
            OP_SRL:  return SH_RLOG;
            OP_SRA:  return SH_RARI;
            default: return SH_LEFT;
        endcase
    endfunction

endpackage

// File: rtl/iou_operand_b.sv
module iou_operand_b #(
    parameter int DW   = 64,
    parameter int IMMW = 8
) (
    input  logic            use_imm,
    input  logic            inv_en,
    input  logic [DW-1:0]   b_reg,
    input  logic [IMMW-1:0] imm,
    output logic [DW-1:0]   b_plain,
    output logic [DW-1:0]   b_logic
);
    localparam int PADW = DW - IMMW;

    logic [DW-1:0] imm_ext;

    assign imm_ext = {{PADW{1'b0}}, imm};

    always_comb begin
        b_plain = use_imm ? imm_ext : b_reg;
        b_logic = inv_en ? ~b_plain : b_plain;
    end
endmodule

// File: rtl/iou_arith.sv
module iou_arith
    import iou_pkg::*;
#(
    parameter int DW = 64,
    parameter int LW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  scale_e        scale,
    input  logic          sub,
    input  logic          long_mode,
    output logic [DW-1:0] sum
);
    localparam int EXTW = DW - LW;

    logic [DW-1:0] a_scaled;
    logic [DW-1:0] raw;

    always_comb begin
        case (scale)
            SC_X4:   a_scaled = {a[DW-3:0], 2'b00};
            SC_X8:   a_scaled = {a[DW-4:0], 3'b000};
            default: a_scaled = a;
        endcase
        raw = sub ? (a_scaled - b) : (a_scaled + b);
        if (long_mode)
            sum = {{EXTW{raw[LW-1]}}, raw[LW-1:0]};
        else
            sum = raw;
    end
endmodule

// File: rtl/iou_logic.sv
module iou_logic
    import iou_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  op_e           op,
    output logic [DW-1:0] y
);
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            default: y = a ^ b;
        endcase
    end
endmodule

// File: rtl/iou_shift.sv
module iou_shift
    import iou_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0]         a,
    input  logic [$clog2(DW)-1:0] cnt,
    input  shdir_e                dir,
    output logic [DW-1:0]         y
);
    localparam int SHW = $clog2(DW);

    logic [DW-1:0] lst [0:SHW];
    logic [DW-1:0] rst_g [0:SHW];
    logic          fill;

    assign fill   = (dir == SH_RARI) ? a[DW-1] : 1'b0;
    assign lst[0] = a;
    assign rst_g[0] = a;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign lst[s+1]   = cnt[s] ? {lst[s][DW-1-D:0], {D{1'b0}}} : lst[s];
        assign rst_g[s+1] = cnt[s] ? {{D{fill}}, rst_g[s][DW-1:D]} : rst_g[s];
    end

    assign y = (dir == SH_LEFT) ? lst[SHW] : rst_g[SHW];
endmodule

// File: rtl/int_op_unit.sv
module int_op_unit
    import iou_pkg::*;
#(
    parameter int DW   = 64,
    parameter int IMMW = 8,
    parameter int LW   = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [2:0]      op,
    input  logic [1:0]      scale,
    input  logic            long_mode,
    input  logic            inv_b,
    input  logic            use_imm,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b_reg,
    input  logic [IMMW-1:0] imm,
    output logic            out_valid,
    output logic [DW-1:0]   result
);
    localparam int SHW = $clog2(DW);

    op_e           op_q;
    scale_e        scale_q;
    logic [DW-1:0] b_plain, b_logic;
    logic [DW-1:0] arith_y, logic_y, shift_y;
    logic [DW-1:0] next_y;

    assign op_q    = op_e'(op);
    assign scale_q = scale_e'(scale);

    iou_operand_b #(.DW(DW), .IMMW(IMMW)) u_opb (
        .use_imm (use_imm),
        .inv_en  (inv_b & is_logic(op_q)),
        .b_reg   (b_reg),
        .imm     (imm),
        .b_plain (b_plain),
        .b_logic (b_logic)
    );

    iou_arith #(.DW(DW), .LW(LW)) u_arith (
        .a         (a),
        .b         (b_plain),
        .scale     (scale_q),
        .sub       (op_q == OP_SUB),
        .long_mode (long_mode),
        .sum       (arith_y)
    );

    iou_logic #(.DW(DW)) u_logic (
        .a  (a),
        .b  (b_logic),
        .op (op_q),
        .y  (logic_y)
    );

    iou_shift #(.DW(DW)) u_shift (
        .a   (a),
        .cnt (b_plain[SHW-1:0]),
        .dir (shift_dir(op_q)),
        .y   (shift_y)
    );

    always_comb begin
        if (is_arith(op_q))
            next_y = arith_y;
        else if (is_logic(op_q))
            next_y = logic_y;
        else
            next_y = shift_y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= next_y;
        end
    end
endmodule

// File: rtl/iou_checker.sv
module iou_checker #(
    parameter int DW   = 64,
    parameter int IMMW = 8,
    parameter int LW   = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [2:0]      op,
    input logic            long_mode,
    input logic            use_imm,
    input logic [DW-1:0]   a,
    input logic [DW-1:0]   b_reg,
    input logic [IMMW-1:0] imm,
    input logic            out_valid,
    input logic [DW-1:0]   result
);
    localparam int SHW = $clog2(DW);

    logic [SHW-1:0] cnt_seen;
    assign cnt_seen = use_imm ? imm[SHW-1:0] : b_reg[SHW-1:0];

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid && result == '0);

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R5
    long_ext_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && long_mode && (op == 3'd0 || op == 3'd1)
        |=> (result[DW-1:LW] == '0) || (&result[DW-1:LW-1]));

    // R8
    sra_sign_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && op == 3'd7 |=> result[DW-1] == $past(a[DW-1]));

    // R7
    srl_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && op == 3'd6 && cnt_seen != '0 |=> !result[DW-1]);

    // R6
    and_zero_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && op == 3'd2 && a == '0 |=> result == '0);
endmodule

bind int_op_unit iou_checker #(.DW(DW), .IMMW(IMMW), .LW(LW)) u_iou_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .long_mode (long_mode),
    .use_imm   (use_imm),
    .a         (a),
    .b_reg     (b_reg),
    .imm       (imm),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/int_op_unit_bench.sv
module int_op_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op;
    logic [1:0]  scale;
    logic        long_mode, inv_b, use_imm;
    logic [63:0] a, b_reg;
    logic [7:0]  imm;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    int_op_unit u_int_op_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .scale(scale),
        .long_mode(long_mode), .inv_b(inv_b), .use_imm(use_imm),
        .a(a), .b_reg(b_reg), .imm(imm), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(
        input logic [2:0] o, input logic [1:0] sc, input logic lg, input logic iv,
        input logic ui, input logic [63:0] av, input logic [63:0] br, input logic [7:0] im);
        logic [63:0] bb, sa, r;
        logic [5:0]  n;
        bb = ui ? {56'd0, im} : br;
        n  = bb[5:0];
        sa = (sc == 2'd1) ? av * 64'd4 : (sc == 2'd2) ? av * 64'd8 : av;
        case (o)
            3'd0, 3'd1: begin
                r = (o == 3'd0) ? sa + bb : sa - bb;
                if (lg) r = {{32{r[31]}}, r[31:0]};
            end
            3'd2: r = av & (iv ? ~bb : bb);
            3'd3: r = av | (iv ? ~bb : bb);
            3'd4: r = av ^ (iv ? ~bb : bb);
            3'd5: r = av << n;
            3'd6: r = av >> n;
            default: r = 64'($signed(av) >>> n);
        endcase
        return r;
    endfunction

    function automatic string tag(input logic [2:0] o, input logic [1:0] sc,
                                  input logic lg, input logic ui);
        if (ui) return "R9";
        if (o <= 3'd1) return lg ? "R5" : (sc != 2'd0 ? "R4" : "R3");
        if (o <= 3'd4) return "R6";
        if (o == 3'd7) return "R8";
        return "R7";
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic [1:0] sc, input logic lg,
                          input logic iv, input logic ui, input logic [63:0] av,
                          input logic [63:0] br, input logic [7:0] im);
        logic [63:0] exp;
        @(negedge clk);
        op = o; scale = sc; long_mode = lg; inv_b = iv; use_imm = ui;
        a = av; b_reg = br; imm = im; in_valid = 1'b1;
        exp = model(o, sc, lg, iv, ui, av, br, im);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", {63'd0, out_valid}, 64'd1);
        // R10: modifier combinations that must not matter share the same model value
        check((o >= 3'd2 && (sc != 0 || lg)) || (o < 3'd2 && iv) ? "R10" : tag(o, sc, lg, ui),
              result, exp);
    endtask

    logic [63:0] pa [0:5];
    logic [63:0] pb [0:5];

    initial begin
        pa[0] = 64'h0; pa[1] = 64'h1; pa[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        pa[3] = 64'h8000_0000_0000_0001; pa[4] = 64'h1234_5678_9ABC_DEF0;
        pa[5] = 64'h2000_0000_7FFF_FFFF;
        pb[0] = 64'h0; pb[1] = 64'h3F; pb[2] = 64'hFFFF_FFFF_FFFF_FFC1;
        pb[3] = 64'h7FFF_FFFF_FFFF_FF05; pb[4] = 64'hDEAD_BEEF_0000_0020;
        pb[5] = 64'h0000_0000_8000_0000;

        in_valid = 0; op = 0; scale = 0; long_mode = 0; inv_b = 0; use_imm = 0;
        a = 0; b_reg = 0; imm = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {63'd0, out_valid}, 64'd0);
        check("R1", result, 64'd0);
        rst = 1'b0;

        for (int o = 0; o < 8; o++)
            for (int sc = 0; sc < 4; sc++)
                for (int m = 0; m < 8; m++)
                    for (int i = 0; i < 6; i++)
                        for (int j = 0; j < 6; j++)
                            run_op(3'(o), 2'(sc), m[0], m[1], m[2], pa[i], pb[j],
                                   pb[j][7:0] ^ 8'(i * 37));

        // R2: idle cycles hold the last result
        run_op(3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 64'd5, 64'd7, 8'd0);
        a = 64'hFFFF; b_reg = 64'hFFFF; op = 3'd4;
        repeat (3) begin
            @(negedge clk);
            check("R2", {63'd0, out_valid}, 64'd0);
            check("R2", result, 64'd12);
        end

        // R9: b_reg ignored when the immediate is selected
        run_op(3'd3, 2'd0, 1'b0, 1'b1, 1'b1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F);
        check("R9", result, 64'hFFFF_FFFF_FFFF_FFF0);

        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (190000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule